// File: doc/BRIEF.md
# Serial Register Port with Result-Ready Flag

This block is the host-side serial interface of a converter peripheral. A host drives a four-wire SPI link in mode 0. The clock idles low, the block samples input on the rising clock edge, and it changes its output on the falling edge. Through this link the host reads and writes a small set of internal registers that are 8, 16 or 24 bits wide. Each transfer opens with a command byte that selects the direction and the register. The register data follows, and the number of data bits equals the width of the addressed register.

The block also receives conversion results from a producer in the master-clock domain. A result arrives as a one-cycle strobe with a 24-bit value. The block waits four master clocks and then copies the value into a read-only result register. An active-low ready output tells the host when an unread result is waiting. Ready goes high before each register update and goes high again when the host reads the result completely. It stays high for the first four results after reset or after a run-start pulse.

The serial clock, chip select and data input are resynchronized into the master-clock domain. For this reason the master clock must run well above the serial clock: at least four times faster, with more margin for reads.

Top module: `spi_regport`

## Requirements
- R1: After reset, `rdy_n` is 1 and `sdo_oe` is 0.
- R2: `sdo_oe` is 1 while `cs_n` is low and 0 while `cs_n` is high.
- R3: A transfer sends a command byte MSB first.
  - Bit 7 selects the direction: 1 means read and 0 means write.
  - Bits 5:1 hold the register address. Bits 6 and 0 are ignored.
  - The data follows MSB first, one bit per serial clock.
  - Address 0 is 8 bits wide, address 1 is 16 bits, address 2 is 24 bits, and address 3 is the 24-bit read-only result register.
  - Every other address is 8 bits wide and reads as 0.
- R4: A completed write to address 0, 1 or 2 stores the bits that were sent. A later read of that address returns those bits.
- R5: A rise of `cs_n` before a transfer is complete aborts it. An aborted write changes no register. The next transfer decodes a fresh command byte.
- R6: A write to address 3 or to an unused address has no effect. The block changes the result register only when a result lands.
- R7: A result strobe in cycle T drives `rdy_n` high from the edge of T. `rdy_n` stays high through edge T+3. The new value enters the result register at edge T+4.
- R8: After reset or a `run_start` pulse, the first four landed results leave `rdy_n` high. The fifth and every later landing drives `rdy_n` low.
- R9: A read of the result register drives `rdy_n` high once all 24 data bits have been clocked in. A read that is aborted earlier leaves `rdy_n` low.
- R10: If a result is never read, `rdy_n` goes from low to high for exactly four master clocks. It then returns low, and the new value can be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` driver, high while selected |
| res_valid | input | 1 | One-cycle strobe marking a new conversion result |
| res_data | input | DATA_W | Conversion result value |
| run_start | input | 1 | One-cycle pulse that begins a continuous run and restarts the warm-up count |
| rdy_n | output | 1 | Result ready, active low |

## Verification
A wrong bit counter or a bad command decode shows at the ports within one transfer. It appears as a shifted or truncated readback, or as a write that lands in the wrong register or is lost. A fault in the landing countdown or in the warm-up count appears at `rdy_n` within five master clocks of a strobe. It shows as a pulse of the wrong length or as a low level during warm-up. A fault in read-completion tracking appears on the first full or partial read of the result register: `rdy_n` either fails to rise at the end of the read or rises when the read is cut short.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  localparam int CMD_BITS = 8;
  localparam int ADDR_W   = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 5'd1;
  localparam logic [ADDR_W-1:0] A_OFS  = 5'd2;
  localparam logic [ADDR_W-1:0] A_RES  = 5'd3;

  // data bits carried by one transfer to the given address
  function automatic int unsigned reg_width(logic [ADDR_W-1:0] a, int unsigned dw);
    case (a)
      A_CTRL:       return 8;
      A_CFG:        return 16;
      A_OFS, A_RES: return dw;
      default:      return 8;
    endcase
  endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int         W      = 3,
  parameter int         STAGES = 2,
  parameter logic [2:0] RSTV   = 3'b001
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         rst_n_o
);

  logic [STAGES-1:0] rst_pipe;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = rst_pipe[STAGES-1];

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n_o) begin
      if (!rst_n_o) pipe <= {STAGES{RSTV[i]}};
      else          pipe <= {pipe[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = pipe[STAGES-1];
  end

endmodule

// File: rtl/spi_regport_serial.sv
module spi_regport_serial
  import spi_regport_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_val_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_last_o,
  output logic              sdo_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CMD_BITS + DATA_W);
  localparam logic [CNT_W-1:0] CMD_END = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] CMD_LEN = CNT_W'(CMD_BITS);

  logic              sck_prev;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [6:0]        cmd_q, cmd_d;
  logic [7:0]        cmd_nx;
  logic              rw_q, rw_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wsh_q, wsh_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              sdo_q, sdo_d;
  logic              done_q, done_d;
  logic              sck_rise, sck_fall, in_cmd;
  logic [CNT_W-1:0]  w_c, end_c;
  int unsigned       w_i;
  logic              unused_bits;

  assign sck_rise = sck_s & ~sck_prev & ~cs_hi;
  assign sck_fall = ~sck_s & sck_prev & ~cs_hi;
  assign in_cmd   = cnt_q < CMD_LEN;
  assign cmd_nx   = {cmd_q, sdi_s};
  assign w_i      = reg_width(addr_q, DATA_W);
  assign w_c      = CNT_W'(w_i);
  assign end_c    = CMD_LEN + w_c - CNT_W'(1);

  always_comb begin
    cnt_d     = cnt_q;
    cmd_d     = cmd_q;
    rw_d      = rw_q;
    addr_d    = addr_q;
    wsh_d     = wsh_q;
    tx_d      = tx_q;
    sdo_d     = sdo_q;
    done_d    = 1'b0;
    wr_en_o   = 1'b0;
    rd_last_o = 1'b0;
    if (cs_hi) begin
      cnt_d = '0;
      sdo_d = 1'b0;
    end else begin
      if (sck_rise) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
        if (in_cmd) begin
          cmd_d = cmd_nx[6:0];
          if (cnt_q == CMD_END) begin
            rw_d   = cmd_nx[7];
            addr_d = cmd_nx[5:1];
            done_d = 1'b1;
          end
        end else if (cnt_q <= end_c) begin
          if (!rw_q) begin
            wsh_d = {wsh_q[DATA_W-2:0], sdi_s};
            if (cnt_q == end_c) wr_en_o = 1'b1;
          end else if (cnt_q == end_c) begin
            rd_last_o = 1'b1;
          end
        end
      end
      if (sck_fall) begin
        if (!in_cmd && rw_q) begin
          sdo_d = tx_q[DATA_W-1];
          tx_d  = tx_q << 1;
        end else begin
          sdo_d = 1'b0;
        end
      end
      if (done_q) tx_d = rd_val_i << (DATA_W - int'(w_i));
    end
  end

  assign wr_data_o   = wsh_d;
  assign addr_o      = addr_q;
  assign sdo_o       = sdo_q;
  assign unused_bits = ^{cmd_nx[6], cmd_nx[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      cnt_q    <= '0;
      cmd_q    <= '0;
      rw_q     <= 1'b0;
      addr_q   <= '0;
      wsh_q    <= '0;
      tx_q     <= '0;
      sdo_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      cnt_q    <= cnt_d;
      cmd_q    <= cmd_d;
      rw_q     <= rw_d;
      addr_q   <= addr_d;
      wsh_q    <= wsh_d;
      tx_q     <= tx_d;
      sdo_q    <= sdo_d;
      done_q   <= done_d;
    end
  end

  // R5: deselect always returns the bit counter to the command start
  a_r5_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (cnt_q == '0));

  // R3: counter never passes command plus widest register
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R6: no register write while deselected
  a_r6_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |-> !wr_en_o);

endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs
  import spi_regport_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] res_i,
  output logic [DATA_W-1:0] rd_val_o
);

  logic [7:0]        ctrl_q, ctrl_d;
  logic [15:0]       cfg_q,  cfg_d;
  logic [DATA_W-1:0] ofs_q,  ofs_d;

  always_comb begin
    ctrl_d = ctrl_q;
    cfg_d  = cfg_q;
    ofs_d  = ofs_q;
    if (wr_en_i) begin
      case (addr_i)
        A_CTRL:  ctrl_d = wr_data_i[7:0];
        A_CFG:   cfg_d  = wr_data_i[15:0];
        A_OFS:   ofs_d  = wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rd_val_o = DATA_W'(ctrl_q);
      A_CFG:   rd_val_o = DATA_W'(cfg_q);
      A_OFS:   rd_val_o = ofs_q;
      A_RES:   rd_val_o = res_i;
      default: rd_val_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      ofs_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cfg_q  <= cfg_d;
      ofs_q  <= ofs_d;
    end
  end

  // R4: a write to the control register shows in its readback next cycle
  a_r4_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_CTRL) |=> (ctrl_q == $past(wr_data_i[7:0])));

endmodule

// File: rtl/spi_regport_ready.sv
module spi_regport_ready
  import spi_regport_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int LAND_DLY = 4,
  parameter int WARMUP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              run_start_i,
  input  logic              rd_last_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_n_o
);

  localparam int PEND_W = $clog2(LAND_DLY + 1);
  localparam int WARM_W = $clog2(WARMUP + 1);
  localparam logic [PEND_W-1:0] PEND_LOAD = PEND_W'(LAND_DLY);
  localparam logic [WARM_W-1:0] WARM_FULL = WARM_W'(WARMUP);

  logic [PEND_W-1:0] pend_q, pend_d;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              rdy_q, rdy_d;
  logic              land, read_done;

  assign land      = (pend_q == PEND_W'(1));
  assign read_done = rd_last_i && (rd_addr_i == A_RES);

  always_comb begin
    pend_d = pend_q;
    warm_d = warm_q;
    hold_d = hold_q;
    data_d = data_q;
    rdy_d  = rdy_q;
    if (pend_q != '0) pend_d = pend_q - PEND_W'(1);
    if (res_valid_i && pend_q == '0) begin
      pend_d = PEND_LOAD;
      hold_d = res_data_i;
      rdy_d  = 1'b1;
    end
    if (read_done) rdy_d = 1'b1;
    if (land) begin
      data_d = hold_q;
      if (warm_q == WARM_FULL) begin
        rdy_d = 1'b0;
      end else begin
        warm_d = warm_q + WARM_W'(1);
        rdy_d  = 1'b1;
      end
    end
    if (run_start_i) begin
      warm_d = '0;
      rdy_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      warm_q <= '0;
      hold_q <= '0;
      data_q <= '0;
      rdy_q  <= 1'b1;
    end else begin
      pend_q <= pend_d;
      warm_q <= warm_d;
      hold_q <= hold_d;
      data_q <= data_d;
      rdy_q  <= rdy_d;
    end
  end

  assign data_o  = data_q;
  assign rdy_n_o = rdy_q;

  // R7: ready is high for the whole countdown before an update
  a_r7_high_before_update: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |-> rdy_n_o);

  // R8: warm-up landings keep ready high
  a_r8_warmup_high: assert property (@(posedge clk) disable iff (!rst_n)
    (land && warm_q != WARM_FULL) |=> rdy_n_o);

  // R9: a completed result read raises ready
  a_r9_read_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (read_done && !land) |=> rdy_n_o);

  // R10: a landing past warm-up drops ready
  a_r10_land_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (land && warm_q == WARM_FULL && !run_start_i) |=> !rdy_n_o);

  // R6: the result register moves only on a landing
  a_r6_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !land |=> $stable(data_q));

endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int LAND_DLY    = 4,
  parameter int WARMUP      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              run_start,
  output logic              rdy_n
);

  localparam int CNT_W = $clog2(CMD_BITS + DATA_W + 1);

  logic [2:0]        pins_s;
  logic              rst_s_n;
  logic [ADDR_W-1:0] addr;
  logic              wr_en, rd_last;
  logic [DATA_W-1:0] wr_data, rd_val, res_q;

  spi_regport_sync #(.W(3), .STAGES(SYNC_STAGES), .RSTV(3'b001)) u_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .d_i     ({sdi, sck, cs_n}),
    .q_o     (pins_s),
    .rst_n_o (rst_s_n)
  );

  spi_regport_serial #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_serial (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cs_hi     (pins_s[0]),
    .sck_s     (pins_s[1]),
    .sdi_s     (pins_s[2]),
    .rd_val_i  (rd_val),
    .addr_o    (addr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .rd_last_o (rd_last),
    .sdo_o     (sdo)
  );

  spi_regport_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wr_data_i (wr_data),
    .res_i     (res_q),
    .rd_val_o  (rd_val)
  );

  spi_regport_ready #(.DATA_W(DATA_W), .LAND_DLY(LAND_DLY), .WARMUP(WARMUP)) u_ready (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .res_valid_i (res_valid),
    .res_data_i  (res_data),
    .run_start_i (run_start),
    .rd_last_i   (rd_last),
    .rd_addr_i   (addr),
    .data_o      (res_q),
    .rdy_n_o     (rdy_n)
  );

  assign sdo_oe = ~cs_n;

endmodule

// File: tb/spi_regport_bench.sv
module spi_regport_bench;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sck, sdi, res_valid, run_start;
  logic [23:0] res_data;
  logic        sdo, sdo_oe, rdy_n;

  int n_tests = 0;
  int n_fail  = 0;

  bit [7:0]  m_ctrl;
  bit [15:0] m_cfg;
  bit [23:0] m_ofs, m_res;

  always #2 clk = ~clk;

  spi_regport u_spi_regport (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .res_valid(res_valid), .res_data(res_data),
    .run_start(run_start), .rdy_n(rdy_n)
  );

  function automatic int width_of(bit [4:0] a);
    case (a)
      5'd0: return 8;
      5'd1: return 16;
      5'd2, 5'd3: return 24;
      default: return 8;
    endcase
  endfunction

  function automatic bit [23:0] model_read(bit [4:0] a);
    case (a)
      5'd0: return {16'd0, m_ctrl};
      5'd1: return {8'd0, m_cfg};
      5'd2: return m_ofs;
      5'd3: return m_res;
      default: return 24'd0;
    endcase
  endfunction

  task automatic check(input string req, input bit [23:0] got, input bit [23:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xfer(input bit rd, input bit [4:0] a, input bit [23:0] wv,
                      input int nd, output bit [23:0] rv);
    bit [7:0] cmd;
    int w;
    cmd = {rd, 1'b0, a, 1'b0};
    w   = width_of(a);
    rv  = '0;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8 + nd; i++) begin
      if (i < 8) sdi = cmd[7-i];
      else       sdi = (i - 8 < w) ? wv[w-1-(i-8)] : 1'b0;
      repeat (8) @(negedge clk);
      if (i >= 8) rv = {rv[22:0], sdo};
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic write_reg(input bit [4:0] a, input bit [23:0] v);
    bit [23:0] dummy;
    xfer(1'b0, a, v, width_of(a), dummy);
    case (a)
      5'd0: m_ctrl = v[7:0];
      5'd1: m_cfg  = v[15:0];
      5'd2: m_ofs  = v;
      default: ;
    endcase
  endtask

  task automatic read_check(input string req, input bit [4:0] a);
    bit [23:0] rv;
    xfer(1'b1, a, 24'd0, width_of(a), rv);
    check(req, rv, model_read(a));
  endtask

  // strobe at edge T; rdy_n high after T..T+3; value lands at T+4
  task automatic strobe(input bit [23:0] v, input bit final_rdy);
    @(negedge clk);
    res_valid = 1'b1;
    res_data  = v;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) res_valid = 1'b0;
      check("R7 high before update", {23'd0, rdy_n}, 24'd1);
    end
    @(negedge clk);
    m_res = v;
    check("R8/R10 level after landing", {23'd0, rdy_n}, {23'd0, final_rdy});
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit [23:0] rv;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    res_valid = 1'b0; res_data = '0; run_start = 1'b0;
    m_ctrl = '0; m_cfg = '0; m_ofs = '0; m_res = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 rdy_n after reset", {23'd0, rdy_n}, 24'd1);
    check("R1 sdo_oe after reset", {23'd0, sdo_oe}, 24'd0);

    cs_n = 1'b0;
    @(negedge clk);
    check("R2 sdo_oe selected", {23'd0, sdo_oe}, 24'd1);
    cs_n = 1'b1;
    @(negedge clk);
    check("R2 sdo_oe released", {23'd0, sdo_oe}, 24'd0);
    repeat (5) @(negedge clk);

    // R3 R4 directed widths
    write_reg(5'd0, 24'h0000A5);
    write_reg(5'd1, 24'h001234);
    write_reg(5'd2, 24'hABCDEF);
    read_check("R3 R4 ctrl 8-bit", 5'd0);
    read_check("R3 R4 cfg 16-bit", 5'd1);
    read_check("R3 R4 ofs 24-bit", 5'd2);
    read_check("R3 unused reads zero", 5'd9);

    // R4 R6 random mix
    for (int it = 0; it < 30; it++) begin
      bit [4:0]  a;
      bit [23:0] v;
      a = 5'($urandom % 8);
      v = 24'($urandom);
      write_reg(a, v);
      read_check("R4 R6 random readback", a);
    end

    // R5 aborted write and aborted command
    xfer(1'b0, 5'd1, 24'h00BEEF, 4, rv);
    read_check("R5 aborted write keeps cfg", 5'd1);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    read_check("R5 fresh command after abort", 5'd0);

    // R7 R8 warm-up
    @(negedge clk);
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    repeat (5) @(negedge clk);
    strobe(24'h111111, 1'b1);
    strobe(24'h222222, 1'b1);
    strobe(24'h333333, 1'b1);
    strobe(24'h444444, 1'b1);
    strobe(24'h555555, 1'b0);
    check("R8 low after fifth result", {23'd0, rdy_n}, 24'd0);

    // R6 write to result register ignored
    write_reg(5'd3, 24'h777777);
    read_check("R6 R9 result read", 5'd3);
    check("R9 rdy_n high after full read", {23'd0, rdy_n}, 24'd1);

    // R10 read then unread result
    strobe(24'h666666, 1'b0);
    strobe(24'h0F0F0F, 1'b0);
    read_check("R10 unread overwritten value", 5'd3);
    check("R10 R9 high after read", {23'd0, rdy_n}, 24'd1);

    // R9 partial read keeps ready low
    strobe(24'hC3C3C3, 1'b0);
    xfer(1'b1, 5'd3, 24'd0, 10, rv);
    check("R9 partial read keeps low", {23'd0, rdy_n}, 24'd0);
    read_check("R9 full read value", 5'd3);
    check("R9 high after full read", {23'd0, rdy_n}, 24'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule